// File: doc/BRIEF.md
# Keyboard Serial-to-Packet Bridge

This block turns keycodes from an external keyboard controller into network event packets. The controller sends one byte per key over a single asynchronous serial line. Each byte uses one start bit, eight data bits (least significant first) and one stop bit. The block samples that line at sixteen times the bit rate and checks the start bit at its middle. It takes each data bit at mid-bit and accepts the byte only when the stop bit reads high.

Each accepted byte is one whole keycode. The block queues it and then wraps it into a 72-bit event packet. That packet goes out on a valid/ready port. It carries the block's own source ID 0x05, the key-event opcode 0x01, zero flags, the keycode zero-extended into a 32-bit payload, and a zero reserved field. The destination comes from a register. Software loads that register by sending a configuration packet to the block over the inbound valid/ready port.

The serial receiver has five states:
- RX_IDLE moves to RX_START on a low line.
- RX_START returns to RX_IDLE (a false start) if the line is high again at mid-bit. Otherwise it moves to RX_DATA.
- RX_DATA moves to RX_STOP after the eighth bit.
- RX_STOP moves to RX_IDLE on a good stop bit, which delivers the byte. On a low stop bit it moves to RX_WAIT_HIGH, which raises a framing error.
- RX_WAIT_HIGH moves to RX_IDLE once the line is high again.

The packet sender has two states:
- TX_IDLE moves to TX_HOLD when a keycode is queued. On that move it pops the keycode and builds the packet with the current destination.
- TX_HOLD moves back to TX_IDLE when the output handshake completes.

Top module: `kbd_event_bridge`

## Requirements
- R1: After reset, `out_valid`, `frame_err` and `overflow` are low, and the destination register holds 0x00. The first event packet therefore carries destination 0x00.
- R2: A serial frame has these parts:
  - a low start bit;
  - eight data bits, least significant first;
  - a high stop bit.
  Each bit lasts OSR×TICK_DIV clocks. Each such frame yields exactly one event packet, whose payload (bits 43:12) is the keycode zero-extended to 32 bits.
- R3: Every event packet is packed most significant field first:
  - destination [71:64];
  - source [63:56] = 0x05;
  - opcode [55:48] = 0x01;
  - flags [47:44] = 0;
  - payload [43:12];
  - reserved [11:0] = 0.
- R4: `in_ready` is high from the first clock after reset. An inbound packet accepted with destination field 0x05 and opcode field 0x02 loads payload bits [19:12] (its low 8 bits) into the destination register. Every packet built afterwards uses that value.
- R5: An inbound packet whose destination field is not 0x05, or whose opcode is not 0x02, leaves the destination register unchanged.
- R6: A low pulse on the serial line that is shorter than half a bit is a false start. It produces no packet and no framing error.
- R7: A frame whose stop bit reads low produces no packet and one single-cycle `frame_err` pulse. The receiver waits for the line to return high before it looks for the next start bit, and the next valid frame is received normally.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_pkt` does not change.
- R9: Keycodes leave in the order they arrived. During a stall the block holds up to five keycodes: one in the output slot and four queued. A further keycode is dropped and sets `overflow`, which stays high until reset.
- R10: An inbound configuration packet may be accepted in the same cycle as an output handshake. In that case the packet being handed over keeps the old destination, and the next packet carries the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_serial | input | 1 | Asynchronous serial keycode line, idle high |
| in_valid | input | 1 | Inbound packet valid |
| in_ready | output | 1 | Inbound packet ready |
| in_pkt | input | 72 | Inbound packet (configuration) |
| out_valid | output | 1 | Event packet valid |
| out_ready | input | 1 | Event packet ready |
| out_pkt | output | 72 | Event packet |
| frame_err | output | 1 | One-cycle pulse on a bad stop bit |
| overflow | output | 1 | Sticky flag: a keycode was dropped |

## Verification
Two functions can fall in the same cycle: a configuration write to the destination register, and the handover of an event packet. The bench stalls the output port until one keycode sits in the output slot and a second waits in the queue. It then raises `out_ready` and presents a configuration packet in the same cycle. The packet handed over in that cycle must still carry the old destination, and the queued keycode must leave with the new one. Two boundaries are also covered: five keycodes during a stall, which must not set the overflow flag, and a sixth, which must be dropped.

// File: rtl/kbd_bridge_pkg.sv
`timescale 1ns/1ps
package kbd_bridge_pkg;
    localparam int ID_W   = 8;
    localparam int OP_W   = 8;
    localparam int FLG_W  = 4;
    localparam int PAY_W  = 32;
    localparam int RSV_W  = 12;
    localparam int KEY_W  = 8;
    localparam int PKT_W  = 2 * ID_W + OP_W + FLG_W + PAY_W + RSV_W;

    typedef struct packed {
        logic [ID_W-1:0]  dst;
        logic [ID_W-1:0]  src;
        logic [OP_W-1:0]  op;
        logic [FLG_W-1:0] flags;
        logic [PAY_W-1:0] payload;
        logic [RSV_W-1:0] rsvd;
    } pkt_t;

    localparam logic [ID_W-1:0] SELF_ID  = 8'h05;
    localparam logic [OP_W-1:0] OP_KEY   = 8'h01;
    localparam logic [OP_W-1:0] OP_CFG   = 8'h02;
    localparam logic [ID_W-1:0] DST_RST  = 8'h00;
endpackage

// File: rtl/kbd_uart_rx.sv
`timescale 1ns/1ps
module kbd_uart_rx #(
    parameter int OSR      = 16,
    parameter int TICK_DIV = 4,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_pin,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data,
    output logic              frame_err
);
    localparam int CNT_W = $clog2(OSR);
    localparam int DIV_W = $clog2(TICK_DIV + 1);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] OS_LAST   = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OSR / 2 - 1);
    localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(TICK_DIV - 1);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(DATA_W - 1);

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT_HIGH
    } rx_state_e;

    rx_state_e         state_q, state_d;
    logic [1:0]        sync_q;
    logic              rx_s;
    logic [DIV_W-1:0]  div_q;
    logic              tick;
    logic [CNT_W-1:0]  os_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] shift_q;
    logic              os_end;

    assign rx_s   = sync_q[1];
    assign tick   = (div_q == DIV_LAST);
    assign os_end = tick && (os_q == OS_LAST);

    // two-flop synchronizer and oversample tick divider
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            div_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], rx_pin};
            div_q  <= tick ? '0 : div_q + 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:      if (!rx_s) state_d = RX_START;
            RX_START:     if (tick && os_q == HALF_LAST)
                              state_d = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:      if (os_end && bit_q == BIT_LAST) state_d = RX_STOP;
            RX_STOP:      if (os_end) state_d = rx_s ? RX_IDLE : RX_WAIT_HIGH;
            RX_WAIT_HIGH: if (rx_s) state_d = RX_IDLE;
            default:      state_d = RX_IDLE;
        endcase
    end

    // state register and bit-level datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            os_q    <= '0;
            bit_q   <= '0;
            shift_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != state_d || os_end)
                os_q <= '0;
            else if (tick)
                os_q <= os_q + 1'b1;
            if (state_q != RX_DATA)
                bit_q <= '0;
            else if (os_end)
                bit_q <= bit_q + 1'b1;
            if (state_q == RX_DATA && os_end)
                shift_q <= {rx_s, shift_q[DATA_W-1:1]};
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_valid <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            byte_valid <= (state_q == RX_STOP) && os_end && rx_s;
            frame_err  <= (state_q == RX_STOP) && os_end && !rx_s;
        end
    end

    assign byte_data = shift_q;
endmodule

// File: rtl/kbd_key_fifo.sv
`timescale 1ns/1ps
module kbd_key_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW:0]   wr_q, rd_q;
    logic          do_push, do_pop;

    assign empty   = (wr_q == rd_q);
    assign full    = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem_q[rd_q[AW-1:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (do_push) wr_q <= wr_q + 1'b1;
            if (do_pop)  rd_q <= rd_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q[AW-1:0]] <= din;
    end
endmodule

// File: rtl/kbd_cfg_sink.sv
`timescale 1ns/1ps
module kbd_cfg_sink
    import kbd_bridge_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  pkt_t            in_pkt,
    output logic            in_ready,
    output logic [ID_W-1:0] dest
);
    logic cfg_hit;
    logic cfg_unused;

    assign cfg_hit    = in_valid && in_ready &&
                        (in_pkt.dst == SELF_ID) && (in_pkt.op == OP_CFG);
    assign cfg_unused = ^{in_pkt.src, in_pkt.flags,
                          in_pkt.payload[PAY_W-1:ID_W], in_pkt.rsvd};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_ready <= 1'b0;
            dest     <= DST_RST;
        end else begin
            in_ready <= 1'b1;
            if (cfg_hit) dest <= in_pkt.payload[ID_W-1:0];
        end
    end
endmodule

// File: rtl/kbd_pkt_tx.sv
`timescale 1ns/1ps
module kbd_pkt_tx
    import kbd_bridge_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_avail,
    input  logic [KEY_W-1:0] key,
    input  logic [ID_W-1:0]  dest,
    output logic             key_pop,
    output logic             out_valid,
    input  logic             out_ready,
    output pkt_t             out_pkt
);
    typedef enum logic {TX_IDLE, TX_HOLD} tx_state_e;

    tx_state_e state_q, state_d;
    pkt_t      built;

    always_comb begin
        built.dst     = dest;
        built.src     = SELF_ID;
        built.op      = OP_KEY;
        built.flags   = '0;
        built.payload = PAY_W'(key);
        built.rsvd    = '0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (key_avail) state_d = TX_HOLD;
            TX_HOLD: if (out_ready) state_d = TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            out_pkt <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TX_IDLE && key_avail) out_pkt <= built;
        end
    end

    always_comb begin
        out_valid = (state_q == TX_HOLD);
        key_pop   = (state_q == TX_IDLE) && key_avail;
    end
endmodule

// File: rtl/kbd_event_bridge.sv
`timescale 1ns/1ps
module kbd_event_bridge
    import kbd_bridge_pkg::*;
#(
    parameter int OSR        = 16,
    parameter int TICK_DIV   = 4,
    parameter int FIFO_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_serial,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PKT_W-1:0] in_pkt,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PKT_W-1:0] out_pkt,
    output logic             frame_err,
    output logic             overflow
);
    logic             byte_valid;
    logic [KEY_W-1:0] byte_data;
    logic [KEY_W-1:0] q_key;
    logic             q_empty, q_full, q_pop;
    logic [ID_W-1:0]  dest;
    pkt_t             tx_pkt;

    kbd_uart_rx #(.OSR(OSR), .TICK_DIV(TICK_DIV), .DATA_W(KEY_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_pin(rx_serial),
        .byte_valid(byte_valid), .byte_data(byte_data), .frame_err(frame_err)
    );

    kbd_key_fifo #(.DEPTH(FIFO_DEPTH), .W(KEY_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(byte_valid), .din(byte_data),
        .pop(q_pop), .dout(q_key), .empty(q_empty), .full(q_full)
    );

    kbd_cfg_sink u_cfg (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pkt(pkt_t'(in_pkt)),
        .in_ready(in_ready), .dest(dest)
    );

    kbd_pkt_tx u_tx (
        .clk(clk), .rst_n(rst_n), .key_avail(!q_empty), .key(q_key),
        .dest(dest), .key_pop(q_pop), .out_valid(out_valid),
        .out_ready(out_ready), .out_pkt(tx_pkt)
    );

    assign out_pkt = tx_pkt;

    always_ff @(posedge clk) begin
        if (!rst_n) overflow <= 1'b0;
        else if (byte_valid && q_full) overflow <= 1'b1;
    end
endmodule

// File: rtl/kbd_event_bridge_chk.sv
`timescale 1ns/1ps
module kbd_event_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        out_valid,
    input logic        out_ready,
    input logic [71:0] out_pkt,
    input logic        frame_err,
    input logic        overflow
);
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pkt)); // R8
    AST_FIXED_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_pkt[63:56] == 8'h05 && out_pkt[55:48] == 8'h01 && out_pkt[47:44] == 4'h0 && out_pkt[11:0] == 12'h000); // R3
    AST_PAYLOAD_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_pkt[43:20] == 24'h0); // R2
    AST_FERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R9
endmodule

bind kbd_event_bridge kbd_event_bridge_chk u_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_pkt(out_pkt), .frame_err(frame_err), .overflow(overflow)
);

// File: tb/kbd_event_bridge_bench.sv
`timescale 1ns/1ps
module kbd_event_bridge_bench;
    localparam int BIT = 64; // OSR 16 x TICK_DIV 4

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_serial = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [71:0] in_pkt = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [71:0] out_pkt;
    logic        frame_err;
    logic        overflow;

    int n_chk = 0;
    int n_fail = 0;
    int ferr_cnt = 0;
    int vld_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    kbd_event_bridge u_kbd_event_bridge (
        .clk(clk), .rst_n(rst_n), .rx_serial(rx_serial),
        .in_valid(in_valid), .in_ready(in_ready), .in_pkt(in_pkt),
        .out_valid(out_valid), .out_ready(out_ready), .out_pkt(out_pkt),
        .frame_err(frame_err), .overflow(overflow)
    );

    always @(negedge clk) begin
        if (frame_err) ferr_cnt++;
        if (out_valid) vld_cnt++;
    end

    function automatic logic [71:0] evt(input logic [7:0] dst, input logic [7:0] key);
        return {dst, 8'h05, 8'h01, 4'h0, 24'h0, key, 12'h000};
    endfunction

    function automatic logic [71:0] inb(input logic [7:0] dst, input logic [7:0] op,
                                        input logic [7:0] val);
        return {dst, 8'h11, op, 4'h0, 24'hABCDEF, val, 12'h000};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [71:0] act,
                       input logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit good_stop);
        @(negedge clk) rx_serial = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_serial = b[i];
            repeat (BIT) @(negedge clk);
        end
        rx_serial = good_stop;
        repeat (BIT) @(negedge clk);
        rx_serial = 1'b1;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic wait_pkt(output logic [71:0] p, output bit got);
        got = 1'b0;
        p = '0;
        for (int i = 0; i < 3000; i++) begin
            if (out_valid) begin
                p = out_pkt;
                got = 1'b1;
                @(negedge clk);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic send_in(input logic [71:0] p);
        @(negedge clk) begin in_pkt = p; in_valid = 1'b1; end
        @(negedge clk) in_valid = 1'b0;
    endtask

    task automatic byte_expect(input logic [7:0] key, input logic [7:0] dst, input string tag);
        logic [71:0] p;
        bit got;
        fork
            send_byte(key, 1'b1);
            wait_pkt(p, got);
        join
        chk(got && p == evt(dst, key), tag, p, evt(dst, key));
    endtask

    task automatic t_reset();
        chk(!out_valid, "R1 out_valid after reset", 72'(out_valid), 72'd0);
        chk(!frame_err, "R1 frame_err after reset", 72'(frame_err), 72'd0);
        chk(!overflow, "R1 overflow after reset", 72'(overflow), 72'd0);
        chk(in_ready, "R4 in_ready after reset", 72'(in_ready), 72'd1);
    endtask

    task automatic t_default_dest();
        byte_expect(8'h41, 8'h00, "R1 R2 R3 default destination key 0x41");
        byte_expect(8'h80, 8'h00, "R2 key 0x80 msb set");
    endtask

    task automatic t_config();
        send_in(inb(8'h05, 8'h02, 8'h37));
        byte_expect(8'hA5, 8'h37, "R4 configured destination 0x37");
    endtask

    task automatic t_ignored();
        send_in(inb(8'h06, 8'h02, 8'h99));
        send_in(inb(8'h05, 8'h03, 8'h99));
        byte_expect(8'h0F, 8'h37, "R5 foreign packets leave destination");
    endtask

    task automatic t_glitch();
        int v0;
        v0 = vld_cnt;
        ferr_cnt = 0;
        @(negedge clk) rx_serial = 1'b0;
        repeat (4) @(negedge clk);
        rx_serial = 1'b1;
        repeat (3 * BIT) @(negedge clk);
        chk(vld_cnt == v0 && ferr_cnt == 0, "R6 short low pulse ignored",
            72'(vld_cnt - v0 + ferr_cnt), 72'd0);
        byte_expect(8'h5A, 8'h37, "R6 receive after false start");
    endtask

    task automatic t_frame_err();
        int v0;
        v0 = vld_cnt;
        ferr_cnt = 0;
        send_byte(8'h3C, 1'b0);
        chk(ferr_cnt == 1, "R7 one frame_err pulse", 72'(ferr_cnt), 72'd1);
        chk(vld_cnt == v0, "R7 no packet on bad stop", 72'(vld_cnt - v0), 72'd0);
        byte_expect(8'hC3, 8'h37, "R7 recovery after framing error");
    endtask

    task automatic t_stall_order();
        logic [71:0] first, p;
        bit got, stable;
        out_ready = 1'b0;
        send_byte(8'h21, 1'b1);
        first = out_pkt;
        stable = 1'b1;
        for (int k = 1; k < 5; k++) begin
            send_byte(8'h21 + 8'(k), 1'b1);
            if (!out_valid || out_pkt != first) stable = 1'b0;
        end
        chk(stable && first == evt(8'h37, 8'h21), "R8 held packet stable", first,
            evt(8'h37, 8'h21));
        chk(!overflow, "R9 five keycodes fit without overflow", 72'(overflow), 72'd0);
        out_ready = 1'b1;
        for (int k = 0; k < 5; k++) begin
            wait_pkt(p, got);
            chk(got && p == evt(8'h37, 8'h21 + 8'(k)), "R9 order after stall", p,
                evt(8'h37, 8'h21 + 8'(k)));
        end
    endtask

    task automatic t_overflow();
        logic [71:0] p;
        bit got;
        int v0;
        out_ready = 1'b0;
        for (int k = 0; k < 6; k++) send_byte(8'h61 + 8'(k), 1'b1);
        chk(overflow, "R9 sixth keycode sets overflow", 72'(overflow), 72'd1);
        out_ready = 1'b1;
        for (int k = 0; k < 5; k++) begin
            wait_pkt(p, got);
            chk(got && p == evt(8'h37, 8'h61 + 8'(k)), "R9 survivors in order", p,
                evt(8'h37, 8'h61 + 8'(k)));
        end
        v0 = vld_cnt;
        repeat (300) @(negedge clk);
        chk(vld_cnt == v0, "R9 dropped keycode never sent", 72'(vld_cnt - v0), 72'd0);
        chk(overflow, "R9 overflow stays set", 72'(overflow), 72'd1);
    endtask

    task automatic t_cfg_race();
        logic [71:0] p;
        bit got;
        out_ready = 1'b0;
        send_byte(8'h11, 1'b1);
        send_byte(8'h22, 1'b1);
        chk(out_valid && out_pkt == evt(8'h37, 8'h11), "R10 slot keeps old destination",
            out_pkt, evt(8'h37, 8'h11));
        in_pkt = inb(8'h05, 8'h02, 8'h2C);
        in_valid = 1'b1;
        out_ready = 1'b1;
        @(negedge clk) in_valid = 1'b0;
        chk(!out_valid, "R10 slot handed over", 72'(out_valid), 72'd0);
        wait_pkt(p, got);
        chk(got && p == evt(8'h2C, 8'h22), "R10 next packet uses new destination", p,
            evt(8'h2C, 8'h22));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_default_dest();
        t_config();
        t_ignored();
        t_glitch();
        t_frame_err();
        t_stall_order();
        t_overflow();
        t_cfg_race();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule